// File: doc/BRIEF.md
# Top-K Sort-and-Select Unit

This block takes a framed stream of unsigned samples and, for every frame, returns the largest K values it holds, largest first. A frame is the run of accepted samples up to and including the one marked with `in_last`. Up to `DEPTH` samples are stored per frame. Once the frame is closed, a selection engine makes one pass over the stored samples for each result. Each pass finds the largest sample not yet chosen and marks it as taken.

The build-time parameter `ARCH` chooses how much hardware the selection uses. The single-comparator build examines one stored entry per cycle, so each pass costs `n` cycles. The grouped build examines `NCMP` entries per cycle. The ping-pong build compares every entry at once and keeps two frame banks: one bank fills while the other is being read. In the single and grouped builds there is only one bank, so the input is held off while a frame is being processed.

The output is a plain valid/last stream with no backpressure. Samples past the depth limit are discarded, and a sticky flag records that this happened.

Top module: `topk_select`

## Requirements
- R1: For a frame whose stored sample count is n, exactly min(K, n) results appear on `out_data`. They are the largest stored values in non-increasing order, and a value that occurs several times among the largest is repeated that many times.
- R2: `out_last` is high with the final result of each frame and low with every other result. It is never high while `out_valid` is low.
- R3: Samples after the first `DEPTH` of a frame are not stored and play no part in that frame's results. Accepting such a sample sets `overflow`, which then stays high until reset.
- R4: While reset is asserted and in the first cycle after it is released, `out_valid` = 0, `overflow` = 0 and `in_ready` = 1.
- R5: In the single (`ARCH`=1) and grouped (`ARCH`=2) builds, `in_ready` is low in the cycle after a sample with `in_last` is accepted. It stays low until that frame's last result has been produced.
- R6: In the ping-pong build (`ARCH`=0), suppose the frames arrive back to back, each has at least K samples, and the unit starts idle. Then `in_ready` never drops.
- R7: For the same accepted input, all three builds produce the same sequence of (`out_data`, `out_last`) values.
- R8: Data and last values presented while `in_valid` is low have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input sample present |
| in_data | input | W | Unsigned sample value |
| in_last | input | 1 | Marks the final sample of a frame |
| in_ready | output | 1 | Unit can accept a sample this cycle |
| out_valid | output | 1 | A result is present |
| out_data | output | W | Result value |
| out_last | output | 1 | Final result of the frame |
| overflow | output | 1 | Sticky: a sample was dropped for exceeding DEPTH |

## Verification
The bench builds three copies of the unit, one per architecture, each with W=4, DEPTH=8, K=3 and NCMP=3. Only sixteen values are possible, so duplicates among the top results are common. Frame lengths are swept from 1 to 8 with ascending, descending, constant and pseudo-random patterns, which covers frames shorter than K, equal to K and filling the whole depth. A group of three comparators does not divide eight entries evenly, so the grouped build's final window in each pass is only partly filled. A final eleven-sample frame ends in maximal values that must be dropped, which exposes the depth limit and the sticky flag.

// File: rtl/topk_pkg.sv
package topk_pkg;

  typedef enum logic [1:0] {
    ARCH_PINGPONG = 2'd0,
    ARCH_SINGLE   = 2'd1,
    ARCH_GROUP    = 2'd2
  } arch_e;

endpackage

// File: rtl/topk_bank.sv
// One frame store: sample registers plus a per-entry "already chosen" mark.
module topk_bank #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [W-1:0]              wr_data,
  input  logic                      clr_used,
  input  logic                      take_en,
  input  logic [IW-1:0]             take_idx,
  output logic [DEPTH-1:0][W-1:0]   data_o,
  output logic [DEPTH-1:0]          used_o
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic we;
    logic te;
    assign we = wr_en && (wr_idx == IW'(e));
    assign te = take_en && (take_idx == IW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  data_o[e] <= '0;
      else if (we) data_o[e] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        used_o[e] <= 1'b0;
      else if (clr_used) used_o[e] <= 1'b0;
      else if (te)       used_o[e] <= 1'b1;
    end
  end

endmodule

// File: rtl/topk_scan.sv
// Combinational window of LANES comparators, chained in ascending index order.
// A later entry replaces the carried best only when strictly greater.
module topk_scan #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  parameter int IW    = $clog2(DEPTH),
  parameter int PW    = $clog2(DEPTH + 1) + 1
) (
  input  logic [DEPTH-1:0][W-1:0] data_i,
  input  logic [DEPTH-1:0]        used_i,
  input  logic [PW-1:0]           len_i,
  input  logic [PW-1:0]           base_i,
  input  logic                    best_ok_i,
  input  logic [W-1:0]            best_val_i,
  input  logic [IW-1:0]           best_idx_i,
  output logic                    best_ok_o,
  output logic [W-1:0]            best_val_o,
  output logic [IW-1:0]           best_idx_o
);

  logic [LANES:0]         ok_c;
  logic [LANES:0][W-1:0]  val_c;
  logic [LANES:0][IW-1:0] idx_c;

  assign ok_c[0]  = best_ok_i;
  assign val_c[0] = best_val_i;
  assign idx_c[0] = best_idx_i;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [PW-1:0] pos;
    logic [W-1:0]  v;
    logic          elig;
    logic          take;
    assign pos  = base_i + PW'(j);
    assign v    = data_i[pos[IW-1:0]];
    assign elig = (pos < len_i) && !used_i[pos[IW-1:0]];
    assign take = elig && (!ok_c[j] || (v > val_c[j]));
    assign ok_c[j+1]  = ok_c[j] | elig;
    assign val_c[j+1] = take ? v : val_c[j];
    assign idx_c[j+1] = take ? pos[IW-1:0] : idx_c[j];
  end

  assign best_ok_o  = ok_c[LANES];
  assign best_val_o = val_c[LANES];
  assign best_idx_o = idx_c[LANES];

endmodule

// File: rtl/topk_select.sv
module topk_select
  import topk_pkg::*;
#(
  parameter arch_e ARCH  = ARCH_GROUP,
  parameter int    NCMP  = 4,
  parameter int    W     = 8,
  parameter int    DEPTH = 16,
  parameter int    K     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         overflow
);

  localparam int NB    = (ARCH == ARCH_PINGPONG) ? 2 : 1;
  localparam int LANES = (ARCH == ARCH_PINGPONG) ? DEPTH :
                         ((ARCH == ARCH_SINGLE) ? 1 : NCMP);
  localparam int IW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PW    = CW + 1;

  // ---------------- state ----------------
  logic                 wsel_q, wsel_d, rsel_q, rsel_d;
  logic [CW-1:0]        wcnt_q, wcnt_d;
  logic [1:0]           full_q, full_d;
  logic [1:0][CW-1:0]   len_q, len_d;
  logic [PW-1:0]        p_q, p_d;
  logic                 bok_q, bok_d;
  logic [W-1:0]         bval_q, bval_d;
  logic [IW-1:0]        bidx_q, bidx_d;
  logic [CW-1:0]        nout_q, nout_d;
  logic                 ov_q, ov_d, ol_q, ol_d, ovf_q, ovf_d;
  logic [W-1:0]         od_q, od_d;

  // ---------------- write side ----------------
  logic          acc, room, wr_en;
  logic [CW-1:0] n_stored;

  assign in_ready = !full_q[wsel_q];
  assign acc      = in_valid && in_ready;
  assign room     = wcnt_q < CW'(DEPTH);
  assign wr_en    = acc && room;
  assign n_stored = wcnt_q + CW'(room);

  // ---------------- banks ----------------
  logic [DEPTH-1:0][W-1:0] bdata [NB];
  logic [DEPTH-1:0]        bused [NB];
  logic [NB-1:0]           b_wr, b_clr, b_take;
  logic [DEPTH-1:0][W-1:0] sel_data;
  logic [DEPTH-1:0]        sel_used;

  logic          rbusy, pass_end, frame_end;
  logic [CW-1:0] rlen, kmax;
  logic          s_ok;
  logic [W-1:0]  s_val;
  logic [IW-1:0] s_idx;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign b_wr[b]   = wr_en && (wsel_q == 1'(b));
    assign b_clr[b]  = acc && in_last && (wsel_q == 1'(b));
    assign b_take[b] = pass_end && (rsel_q == 1'(b));

    topk_bank #(.W(W), .DEPTH(DEPTH), .IW(IW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (b_wr[b]),
      .wr_idx   (wcnt_q[IW-1:0]),
      .wr_data  (in_data),
      .clr_used (b_clr[b]),
      .take_en  (b_take[b]),
      .take_idx (s_idx),
      .data_o   (bdata[b]),
      .used_o   (bused[b])
    );
  end

  if (NB == 2) begin : g_mux2
    assign sel_data = rsel_q ? bdata[1] : bdata[0];
    assign sel_used = rsel_q ? bused[1] : bused[0];
  end else begin : g_mux1
    assign sel_data = bdata[0];
    assign sel_used = bused[0];
  end

  // ---------------- selection ----------------
  assign rbusy     = full_q[rsel_q];
  assign rlen      = len_q[rsel_q];
  assign kmax      = (rlen < CW'(K)) ? rlen : CW'(K);
  assign pass_end  = rbusy && ((p_q + PW'(LANES)) >= PW'(rlen));
  assign frame_end = pass_end && ((nout_q + CW'(1)) == kmax);

  topk_scan #(.W(W), .DEPTH(DEPTH), .LANES(LANES), .IW(IW), .PW(PW)) u_scan (
    .data_i     (sel_data),
    .used_i     (sel_used),
    .len_i      (PW'(rlen)),
    .base_i     (p_q),
    .best_ok_i  (bok_q),
    .best_val_i (bval_q),
    .best_idx_i (bidx_q),
    .best_ok_o  (s_ok),
    .best_val_o (s_val),
    .best_idx_o (s_idx)
  );

  // ---------------- next state ----------------
  always_comb begin
    wsel_d = wsel_q;  rsel_d = rsel_q;  wcnt_d = wcnt_q;
    full_d = full_q;  len_d  = len_q;   p_d    = p_q;
    bok_d  = bok_q;   bval_d = bval_q;  bidx_d = bidx_q;
    nout_d = nout_q;  ovf_d  = ovf_q;
    ov_d   = 1'b0;    ol_d   = 1'b0;    od_d   = od_q;

    if (acc) begin
      if (room) wcnt_d = wcnt_q + CW'(1);
      else      ovf_d  = 1'b1;
      if (in_last) begin
        full_d[wsel_q] = 1'b1;
        len_d[wsel_q]  = n_stored;
        wcnt_d         = '0;
        if (NB == 2) wsel_d = !wsel_q;
      end
    end

    if (rbusy) begin
      if (pass_end) begin
        ov_d   = 1'b1;
        od_d   = s_val;
        ol_d   = frame_end;
        p_d    = '0;
        bok_d  = 1'b0;
        nout_d = nout_q + CW'(1);
        if (frame_end) begin
          full_d[rsel_q] = 1'b0;
          nout_d         = '0;
          if (NB == 2) rsel_d = !rsel_q;
        end
      end else begin
        p_d    = p_q + PW'(LANES);
        bok_d  = s_ok;
        bval_d = s_val;
        bidx_d = s_idx;
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= 1'b0;  rsel_q <= 1'b0;  wcnt_q <= '0;
      full_q <= '0;    len_q  <= '0;    p_q    <= '0;
      bok_q  <= 1'b0;  bval_q <= '0;    bidx_q <= '0;
      nout_q <= '0;    ovf_q  <= 1'b0;
      ov_q   <= 1'b0;  ol_q   <= 1'b0;  od_q   <= '0;
    end else begin
      wsel_q <= wsel_d;  rsel_q <= rsel_d;  wcnt_q <= wcnt_d;
      full_q <= full_d;  len_q  <= len_d;   p_q    <= p_d;
      bok_q  <= bok_d;   bval_q <= bval_d;  bidx_q <= bidx_d;
      nout_q <= nout_d;  ovf_q  <= ovf_d;
      ov_q   <= ov_d;    ol_q   <= ol_d;    od_q   <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;
  assign overflow  = ovf_q;

endmodule

// File: rtl/topk_select_chk.sv
module topk_select_chk
  import topk_pkg::*;
#(
  parameter int    W    = 8,
  parameter int    K    = 4,
  parameter arch_e ARCH = ARCH_GROUP
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_last,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_last,
  input logic         overflow
);

  localparam int KCW = $clog2(K + 1);

  logic           mid_q;
  logic [W-1:0]   prev_q;
  logic [KCW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q  <= 1'b0;
      prev_q <= '0;
      cnt_q  <= '0;
    end else if (out_valid) begin
      mid_q  <= !out_last;
      prev_q <= out_data;
      cnt_q  <= out_last ? '0 : cnt_q + KCW'(1);
    end
  end

  // R1: results inside a frame never increase
  a_r1_descending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mid_q) |-> (out_data <= prev_q));

  // R1: no frame yields more than K results
  a_r1_at_most_k: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (cnt_q == KCW'(K - 1))) |-> out_last);

  // R2: last only accompanies a valid result
  a_r2_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R3: overflow flag is sticky
  a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  if (ARCH != ARCH_PINGPONG) begin : g_stall
    // R5: single-bank builds hold the input off once a frame closes
    a_r5_hold_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> !in_ready);
  end

endmodule

bind topk_select topk_select_chk #(.W(W), .K(K), .ARCH(ARCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_last  (out_last),
  .overflow  (overflow)
);

// File: tb/topk_select_tb.sv
module topk_select_tb;

  localparam int W     = 4;
  localparam int DEPTH = 8;
  localparam int K     = 3;
  localparam int NCMP  = 3;
  localparam int MAXS  = 512;
  localparam int MAXR  = 256;
  localparam int NA    = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit go = 1'b0;
  bit finished = 1'b0;

  // stimulus
  logic [W-1:0] stim_d [MAXS];
  bit stim_l [MAXS], stim_gap [MAXS], stim_rs [MAXS], stim_reg [MAXS], stim_ovc [MAXS];
  int ns = 0;
  // expected
  logic [W-1:0] exp_v [MAXR];
  bit exp_l [MAXR];
  int ne = 0;
  // observed, per architecture (0 ping-pong, 1 single, 2 grouped)
  logic [W-1:0] res_v [NA][MAXR];
  bit res_l [NA][MAXR];
  int nres [NA];
  int stall [NA];
  bit done [NA];
  logic [NA-1:0] ovf_w, ready_w, ovalid_w;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int unsigned lcg(input int unsigned s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  for (genvar a = 0; a < NA; a++) begin : g_arch
    logic         in_valid, in_last, in_ready, out_valid, out_last, overflow;
    logic [W-1:0] in_data, out_data;

    topk_select #(
      .ARCH(topk_pkg::arch_e'(a)), .NCMP(NCMP), .W(W), .DEPTH(DEPTH), .K(K)
    ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .overflow(overflow)
    );

    assign ovf_w[a]    = overflow;
    assign ready_w[a]  = in_ready;
    assign ovalid_w[a] = out_valid;

    always @(negedge clk) begin
      if (rst_n && out_valid) begin
        if (nres[a] < MAXR) begin
          res_v[a][nres[a]] = out_data;
          res_l[a][nres[a]] = out_last;
        end
        nres[a]++;
      end
    end

    initial begin
      in_valid = 1'b0; in_data = '0; in_last = 1'b0;
      nres[a] = 0; stall[a] = 0; done[a] = 1'b0;
      wait (go);
      for (int s = 0; s < ns; s++) begin
        if (stim_rs[s]) begin
          repeat (60) begin @(negedge clk); in_valid = 1'b0; in_last = 1'b0; in_data = '1; end
        end
        if (stim_gap[s]) begin
          // R8: garbage while valid is low
          @(negedge clk); in_valid = 1'b0; in_data = '1; in_last = 1'b1;
        end
        if (stim_ovc[s]) begin
          @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
          chk(overflow == 1'b0, $sformatf("R3 flag before overflow arch=%0d", a), overflow, 0);
        end
        @(negedge clk);
        in_valid = 1'b1; in_data = stim_d[s]; in_last = stim_l[s];
        while (!in_ready) begin
          if (stim_reg[s]) stall[a]++;
          @(negedge clk);
        end
        @(posedge clk);
        if (stim_l[s] && a != 0) begin
          @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
          chk(in_ready == 1'b0, $sformatf("R5 ready after last arch=%0d s=%0d", a, s), in_ready, 0);
        end
      end
      @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
      done[a] = 1'b1;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'h1234_5678;
    // ---- build stimulus and expected results ----
    for (int f = 0; f < 45; f++) begin
      int len, pat, n, nk;
      bit regf, ovfr;
      logic [W-1:0] srt [DEPTH];
      regf = 1'b0; ovfr = 1'b0;
      if (f < 32) begin
        pat = f % 4; len = 1 + f / 4;
      end else if (f < 44) begin
        pat = 3; regf = 1'b1;
        seed = lcg(seed); len = K + int'((seed >> 16) % (DEPTH - K + 1));
      end else begin
        pat = 4; ovfr = 1'b1; len = DEPTH + 3;
      end
      n = (len < DEPTH) ? len : DEPTH;
      for (int i = 0; i < len; i++) begin
        logic [W-1:0] v;
        case (pat)
          0: v = W'(i * 2);
          1: v = W'(15 - i * 2);
          2: v = W'(f % 16);
          3: begin seed = lcg(seed); v = W'((seed >> 16) % 16); end
          default: begin
            seed = lcg(seed);
            v = (i < DEPTH) ? W'((seed >> 16) % 15) : W'(15);
          end
        endcase
        stim_d[ns + i]   = v;
        stim_l[ns + i]   = (i == len - 1);
        stim_gap[ns + i] = !regf && (((ns + i) % 5) == 2);
        stim_rs[ns + i]  = regf && (f == 32) && (i == 0);
        stim_reg[ns + i] = regf;
        stim_ovc[ns + i] = ovfr && (i == 0);
        if (i < DEPTH) begin
          int j;
          j = i;
          while (j > 0 && srt[j-1] < v) begin srt[j] = srt[j-1]; j--; end
          srt[j] = v;
        end
      end
      nk = (n < K) ? n : K;
      for (int r = 0; r < nk; r++) begin
        exp_v[ne] = srt[r];
        exp_l[ne] = (r == nk - 1);
        ne++;
      end
      ns += len;
    end

    // ---- reset ----
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < NA; a++) begin
      chk(ovalid_w[a] == 1'b0, $sformatf("R4 out_valid in reset arch=%0d", a), ovalid_w[a], 0);
      chk(ovf_w[a] == 1'b0, $sformatf("R4 overflow in reset arch=%0d", a), ovf_w[a], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < NA; a++) begin
      chk(ready_w[a] == 1'b1, $sformatf("R4 in_ready after reset arch=%0d", a), ready_w[a], 1);
      chk(ovalid_w[a] == 1'b0, $sformatf("R4 out_valid after reset arch=%0d", a), ovalid_w[a], 0);
    end
    go = 1'b1;

    wait (done[0] && done[1] && done[2]);
    repeat (200) @(negedge clk);

    // ---- compare ----
    for (int a = 0; a < NA; a++) begin
      int mism;
      chk(nres[a] == ne, $sformatf("R1 result count arch=%0d", a), nres[a], ne);
      for (int i = 0; i < ne && i < nres[a]; i++) begin
        chk(res_v[a][i] == exp_v[i], $sformatf("R1 R8 value arch=%0d idx=%0d", a, i),
            res_v[a][i], exp_v[i]);
        chk(res_l[a][i] == exp_l[i], $sformatf("R2 last arch=%0d idx=%0d", a, i),
            res_l[a][i], exp_l[i]);
      end
      chk(ovf_w[a] == 1'b1, $sformatf("R3 flag after overflow arch=%0d", a), ovf_w[a], 1);
      mism = 0;
      if (nres[a] != nres[0]) mism++;
      for (int i = 0; i < nres[a] && i < nres[0] && i < MAXR; i++)
        if (res_v[a][i] != res_v[0][i] || res_l[a][i] != res_l[0][i]) mism++;
      chk(mism == 0, $sformatf("R7 match ping-pong arch=%0d", a), mism, 0);
    end
    chk(stall[0] == 0, "R6 ping-pong stall cycles", stall[0], 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule